// File: doc/BRIEF.md
# 32-bit Instruction Class Decoder

This block sorts a 32-bit instruction word into one of ten instruction classes. Each class is defined by a mask and a compare value. All ten comparisons are evaluated in parallel, and a fixed priority then picks a single winner. Several patterns overlap: a multiply word also satisfies the broad halfword-transfer pattern, and so does a swap word. In such cases the earlier, narrower class always wins.

The decoder reports the winning class as a one-hot vector and always passes the condition nibble through. It also extracts the register and flag fields that belong to the winning class. Fields that the class does not use are driven to zero. It also raises a flag when the program counter (register 15) appears in a slot where the class forbids it. A word that fits no pattern raises an unknown flag instead.

Inputs are the word and a valid strobe. Every output is registered, so a result appears one clock after its word was presented. The decoder does not evaluate the condition and does not execute anything.

Top module: `insn_class_decoder`

## Requirements
- R1: `out_vld` equals the `in_vld` of the previous clock. While `rst_n` is low, every output is zero.
- R2: In a cycle where `out_vld` is low, every other output is zero.
- R3: `out_cls` is one-hot, with these bit positions and match conditions (word AND mask == value):
  - bit 0 branch-exchange: mask 0x0FFFFFF0, value 0x012FFF10
  - bit 1 branch: mask 0x0E000000, value 0x0A000000
  - bit 2 multiply: mask 0x0FC000F0, value 0x00000090
  - bit 3 long multiply: mask 0x0F8000F0, value 0x00800090
  - bit 4 swap: mask 0x0FB00FF0, value 0x01000090
  - bit 5 halfword/signed transfer: mask 0x0E000090, value 0x00000090
  - bit 6 software interrupt: mask 0x0F000000, value 0x0F000000
  - bit 7 coprocessor transfer: mask 0x0E000000, value 0x0C000000
  - bit 8 coprocessor operation: mask 0x0F000010, value 0x0E000000
  - bit 9 coprocessor register transfer: mask 0x0F000010, value 0x0E000010
- R4: When several patterns match, only the lowest-numbered class bit is set. For example, a multiply word that also fits the halfword pattern reports bit 2 only.
- R5: When no pattern matches, `out_unknown` is high, `out_cls` is zero and every field output is zero.
- R6: For a valid word, `out_cond` always equals word bits 31:28, including for unknown words.
- R7: The register fields carry word bits 19:16 (`out_fld_hi`), 15:12 (`out_fld_mid`), 11:8 (`out_fld_sel`) and 3:0 (`out_fld_lo`). Each is zero outside its classes:
  - `out_fld_hi` and `out_fld_mid`: classes 2, 3, 4, 5, 7, 8 and 9.
  - `out_fld_sel`: classes 2, 3, 7, 8 and 9.
  - `out_fld_lo`: classes 0, 2, 3, 4, 5, 8 and 9.
- R8: `out_link` (bit 24) and `out_offset` (bits 23:0) are nonzero only for class 1 (branch).
- R9: `out_cp_info` carries bits 7:5 for classes 8 and 9 only. `out_load` carries bit 20 for classes 5, 7 and 9 only.
- R10: `out_pc_misuse` is set in these cases, and in no others:
  - class 0 with bits 3:0 = 15
  - class 2 or 3 with any of bits 19:16, 15:12, 11:8 or 3:0 = 15
  - class 4 with any of bits 19:16, 15:12 or 3:0 = 15
  - class 5 with bit 22 = 0 and bits 3:0 = 15
  - class 5 with bit 21 = 1 and bits 19:16 = 15

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Word valid strobe |
| in_word | input | 32 | Instruction word |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_cls | output | 10 | One-hot class vector |
| out_unknown | output | 1 | No pattern matched |
| out_cond | output | 4 | Condition nibble |
| out_fld_hi | output | 4 | Bits 19:16 when used by the class |
| out_fld_mid | output | 4 | Bits 15:12 when used by the class |
| out_fld_sel | output | 4 | Bits 11:8 when used by the class |
| out_fld_lo | output | 4 | Bits 3:0 when used by the class |
| out_cp_info | output | 3 | Coprocessor info bits 7:5 |
| out_load | output | 1 | Load direction bit 20 |
| out_link | output | 1 | Branch link bit |
| out_offset | output | 24 | Branch offset |
| out_pc_misuse | output | 1 | Register 15 in a forbidden slot |

## Verification
Two functions can fire on the same word: a narrow class match (multiply, long multiply, swap) and the broad halfword-transfer match. The priority picker must then suppress the broader one. The bench provokes this with directed words that satisfy both masks, and with a long run of random words whose low byte is often forced to the 1001 pattern. Each result is judged against a behavioural model that scans the patterns in order. That model also predicts the fields and the register-15 flag, so a wrong winner shows up as a wrong class bit and also as wrong field zeroing.

// File: rtl/insn_cls_pkg.sv
package insn_cls_pkg;
    localparam int WORD_W  = 32;
    localparam int REG_W   = 4;
    localparam int COND_W  = 4;
    localparam int INFO_W  = 3;
    localparam int OFFS_W  = 24;
    localparam int NUM_CLS = 10;
    localparam int IDX_W   = $clog2(NUM_CLS + 1);

    typedef enum logic [IDX_W-1:0] {
        CLS_BX   = 4'd0,
        CLS_BR   = 4'd1,
        CLS_MUL  = 4'd2,
        CLS_MULL = 4'd3,
        CLS_SWP  = 4'd4,
        CLS_HWT  = 4'd5,
        CLS_SWI  = 4'd6,
        CLS_CPDT = 4'd7,
        CLS_CPDO = 4'd8,
        CLS_CPRT = 4'd9,
        CLS_NONE = 4'd10
    } cls_e;

    typedef struct packed {
        logic [REG_W-1:0]  hi;
        logic [REG_W-1:0]  mid;
        logic [REG_W-1:0]  sel;
        logic [REG_W-1:0]  lo;
        logic [INFO_W-1:0] info;
        logic              load;
        logic              link;
        logic [OFFS_W-1:0] offset;
        logic              pc_bad;
    } fields_t;

    function automatic logic [WORD_W-1:0] pat_mask(input int idx);
        case (idx)
            0:       return 32'h0FFF_FFF0;
            1:       return 32'h0E00_0000;
            2:       return 32'h0FC0_00F0;
            3:       return 32'h0F80_00F0;
            4:       return 32'h0FB0_0FF0;
            5:       return 32'h0E00_0090;
            6:       return 32'h0F00_0000;
            7:       return 32'h0E00_0000;
            8:       return 32'h0F00_0010;
            default: return 32'h0F00_0010;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pat_value(input int idx);
        case (idx)
            0:       return 32'h012F_FF10;
            1:       return 32'h0A00_0000;
            2:       return 32'h0000_0090;
            3:       return 32'h0080_0090;
            4:       return 32'h0100_0090;
            5:       return 32'h0000_0090;
            6:       return 32'h0F00_0000;
            7:       return 32'h0C00_0000;
            8:       return 32'h0E00_0000;
            default: return 32'h0E00_0010;
        endcase
    endfunction
endpackage

// File: rtl/insn_pat_match.sv
module insn_pat_match
    import insn_cls_pkg::*;
#(
    parameter int N = NUM_CLS
) (
    input  logic [WORD_W-1:0] word,
    output logic [N-1:0]      hit
);
    for (genvar g = 0; g < N; g++) begin : g_pat
        assign hit[g] = ((word & pat_mask(g)) == pat_value(g));
    end
endmodule

// File: rtl/insn_prio_pick.sv
module insn_prio_pick
    import insn_cls_pkg::*;
#(
    parameter int N = NUM_CLS
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output cls_e         idx,
    output logic         none
);
    // lowest set bit is the highest priority
    assign grant = req & ~(req - 1'b1);
    assign none  = (req == '0);

    always_comb begin
        idx = CLS_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = cls_e'(i);
        end
    end
endmodule

// File: rtl/insn_field_extract.sv
module insn_field_extract
    import insn_cls_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  cls_e              cls,
    output fields_t           fld
);
    logic [REG_W-1:0] b_hi, b_mid, b_sel, b_lo;
    logic             pc_hi, pc_mid, pc_sel, pc_lo;

    assign b_hi   = word[19:16];
    assign b_mid  = word[15:12];
    assign b_sel  = word[11:8];
    assign b_lo   = word[3:0];
    assign pc_hi  = &b_hi;
    assign pc_mid = &b_mid;
    assign pc_sel = &b_sel;
    assign pc_lo  = &b_lo;

    always_comb begin
        fld = '0;
        unique case (cls)
            CLS_BX: begin
                fld.lo     = b_lo;
                fld.pc_bad = pc_lo;
            end
            CLS_BR: begin
                fld.link   = word[24];
                fld.offset = word[23:0];
            end
            CLS_MUL, CLS_MULL: begin
                fld.hi     = b_hi;
                fld.mid    = b_mid;
                fld.sel    = b_sel;
                fld.lo     = b_lo;
                fld.pc_bad = pc_hi | pc_mid | pc_sel | pc_lo;
            end
            CLS_SWP: begin
                fld.hi     = b_hi;
                fld.mid    = b_mid;
                fld.lo     = b_lo;
                fld.pc_bad = pc_hi | pc_mid | pc_lo;
            end
            CLS_HWT: begin
                fld.hi     = b_hi;
                fld.mid    = b_mid;
                fld.lo     = b_lo;
                fld.load   = word[20];
                fld.pc_bad = (!word[22] && pc_lo) || (word[21] && pc_hi);
            end
            CLS_SWI: begin
                fld = '0;
            end
            CLS_CPDT: begin
                fld.hi   = b_hi;
                fld.mid  = b_mid;
                fld.sel  = b_sel;
                fld.load = word[20];
            end
            CLS_CPDO, CLS_CPRT: begin
                fld.hi   = b_hi;
                fld.mid  = b_mid;
                fld.sel  = b_sel;
                fld.lo   = b_lo;
                fld.info = word[7:5];
                fld.load = (cls == CLS_CPRT) ? word[20] : 1'b0;
            end
            CLS_NONE: begin
                fld = '0;
            end
            default: begin
                fld = '0;
            end
        endcase
    end
endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
    import insn_cls_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [WORD_W-1:0]   in_word,
    output logic                out_vld,
    output logic [NUM_CLS-1:0]  out_cls,
    output logic                out_unknown,
    output logic [COND_W-1:0]   out_cond,
    output logic [REG_W-1:0]    out_fld_hi,
    output logic [REG_W-1:0]    out_fld_mid,
    output logic [REG_W-1:0]    out_fld_sel,
    output logic [REG_W-1:0]    out_fld_lo,
    output logic [INFO_W-1:0]   out_cp_info,
    output logic                out_load,
    output logic                out_link,
    output logic [OFFS_W-1:0]   out_offset,
    output logic                out_pc_misuse
);
    localparam logic [NUM_CLS-1:0] PC_CLS_MASK = NUM_CLS'(10'b00_0011_1101);

    logic [NUM_CLS-1:0] hit, grant;
    cls_e               win;
    logic               no_hit;
    fields_t            fld;

    insn_pat_match #(.N(NUM_CLS)) u_match (
        .word (in_word),
        .hit  (hit)
    );

    insn_prio_pick #(.N(NUM_CLS)) u_pick (
        .req   (hit),
        .grant (grant),
        .idx   (win),
        .none  (no_hit)
    );

    insn_field_extract u_fields (
        .word (in_word),
        .cls  (win),
        .fld  (fld)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !in_vld) begin
            out_vld       <= 1'b0;
            out_cls       <= '0;
            out_unknown   <= 1'b0;
            out_cond      <= '0;
            out_fld_hi    <= '0;
            out_fld_mid   <= '0;
            out_fld_sel   <= '0;
            out_fld_lo    <= '0;
            out_cp_info   <= '0;
            out_load      <= 1'b0;
            out_link      <= 1'b0;
            out_offset    <= '0;
            out_pc_misuse <= 1'b0;
        end else begin
            out_vld       <= 1'b1;
            out_cls       <= grant;
            out_unknown   <= no_hit;
            out_cond      <= in_word[31:28];
            out_fld_hi    <= fld.hi;
            out_fld_mid   <= fld.mid;
            out_fld_sel   <= fld.sel;
            out_fld_lo    <= fld.lo;
            out_cp_info   <= fld.info;
            out_load      <= fld.load;
            out_link      <= fld.link;
            out_offset    <= fld.offset;
            out_pc_misuse <= fld.pc_bad;
        end
    end

    a_r1_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r1_vld_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_cls == '0 && !out_unknown && out_cond == '0 && !out_pc_misuse));
    a_r3_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_unknown) |-> ($countones(out_cls) == 1));
    a_r5_unknown_excl: assert property (@(posedge clk) disable iff (!rst_n)
        out_unknown |-> (out_cls == '0 && out_fld_hi == '0 && out_fld_lo == '0));
    a_r8_offset_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_link || out_offset != '0) |-> out_cls[CLS_BR]);
    a_r10_pc_class: assert property (@(posedge clk) disable iff (!rst_n)
        out_pc_misuse |-> ((out_cls & PC_CLS_MASK) != '0));
endmodule

// File: tb/insn_class_decoder_test.sv
`timescale 1ns/1ps
module insn_class_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_vld, out_unknown, out_load, out_link, out_pc_misuse;
    logic [9:0]  out_cls;
    logic [3:0]  out_cond, out_fld_hi, out_fld_mid, out_fld_sel, out_fld_lo;
    logic [2:0]  out_cp_info;
    logic [23:0] out_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    insn_class_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
        .out_vld(out_vld), .out_cls(out_cls), .out_unknown(out_unknown),
        .out_cond(out_cond), .out_fld_hi(out_fld_hi), .out_fld_mid(out_fld_mid),
        .out_fld_sel(out_fld_sel), .out_fld_lo(out_fld_lo),
        .out_cp_info(out_cp_info), .out_load(out_load), .out_link(out_link),
        .out_offset(out_offset), .out_pc_misuse(out_pc_misuse)
    );

    // expected outputs for the word presented one cycle earlier
    logic        e_vld, e_unk, e_load, e_link, e_pc;
    logic [9:0]  e_cls;
    logic [3:0]  e_cond, e_hi, e_mid, e_sel, e_lo;
    logic [2:0]  e_info;
    logic [23:0] e_off;

    logic [31:0] masks [10] = '{32'h0FFFFFF0, 32'h0E000000, 32'h0FC000F0, 32'h0F8000F0,
                                32'h0FB00FF0, 32'h0E000090, 32'h0F000000, 32'h0E000000,
                                32'h0F000010, 32'h0F000010};
    logic [31:0] vals  [10] = '{32'h012FFF10, 32'h0A000000, 32'h00000090, 32'h00800090,
                                32'h01000090, 32'h00000090, 32'h0F000000, 32'h0C000000,
                                32'h0E000000, 32'h0E000010};

    task automatic clear_exp();
        e_vld = 0; e_unk = 0; e_load = 0; e_link = 0; e_pc = 0;
        e_cls = '0; e_cond = '0; e_hi = '0; e_mid = '0; e_sel = '0; e_lo = '0;
        e_info = '0; e_off = '0;
    endtask

    task automatic model(input logic [31:0] w);
        int k;
        bit f15_hi, f15_mid, f15_sel, f15_lo;
        clear_exp();
        e_vld  = 1;
        e_cond = w[31:28];
        k = -1;
        for (int i = 0; i < 10; i++)
            if (k < 0 && (w & masks[i]) == vals[i]) k = i;
        f15_hi = (w[19:16] == 4'hF); f15_mid = (w[15:12] == 4'hF);
        f15_sel = (w[11:8] == 4'hF); f15_lo = (w[3:0] == 4'hF);
        if (k < 0) begin
            e_unk = 1;
        end else begin
            e_cls[k] = 1'b1;
            if (k inside {2, 3, 4, 5, 7, 8, 9}) begin e_hi = w[19:16]; e_mid = w[15:12]; end
            if (k inside {2, 3, 7, 8, 9}) e_sel = w[11:8];
            if (k inside {0, 2, 3, 4, 5, 8, 9}) e_lo = w[3:0];
            if (k inside {8, 9}) e_info = w[7:5];
            if (k inside {5, 7, 9}) e_load = w[20];
            if (k == 1) begin e_link = w[24]; e_off = w[23:0]; end
            case (k)
                0: e_pc = f15_lo;
                2, 3: e_pc = f15_hi | f15_mid | f15_sel | f15_lo;
                4: e_pc = f15_hi | f15_mid | f15_lo;
                5: e_pc = (!w[22] && f15_lo) || (w[21] && f15_hi);
                default: e_pc = 0;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s word=%h actual=%h expected=%h", tag, in_word, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 out_vld", 32'(out_vld), 32'(e_vld));
        if (!e_vld) chk("R2 idle outputs", {out_cls, out_cond, out_fld_lo, out_unknown},
                        {e_cls, e_cond, e_lo, e_unk});
        chk("R3 out_cls", 32'(out_cls), 32'(e_cls));
        if ($countones(e_cls) == 1 && e_cls[5] == 1'b0 && e_cls[2:0] != '0)
            chk("R4 priority winner", 32'(out_cls), 32'(e_cls));
        chk("R5 out_unknown", 32'(out_unknown), 32'(e_unk));
        chk("R6 out_cond", 32'(out_cond), 32'(e_cond));
        chk("R7 reg fields", {16'h0, out_fld_hi, out_fld_mid, out_fld_sel, out_fld_lo},
                             {16'h0, e_hi, e_mid, e_sel, e_lo});
        chk("R8 link/offset", {7'h0, out_link, out_offset}, {7'h0, e_link, e_off});
        chk("R9 info/load", 32'({out_cp_info, out_load}), 32'({e_info, e_load}));
        chk("R10 pc misuse", 32'(out_pc_misuse), 32'(e_pc));
    endtask

    task automatic step(input bit v, input logic [31:0] w);
        @(negedge clk);
        compare_all();
        in_vld  = v;
        in_word = w;
        if (v) model(w); else clear_exp();
    endtask

    initial begin
        clear_exp();
        in_word = 32'hE1A00000;
        in_vld  = 1'b1;
        repeat (3) begin
            @(negedge clk);
            compare_all();   // R1 reset state
        end
        in_vld = 1'b0;
        rst_n  = 1'b1;
        // directed words, one per class plus overlaps and register-15 cases
        step(1, 32'hE12FFF13);  // R3 branch-exchange
        step(1, 32'hE12FFF1F);  // R10 branch-exchange to r15
        step(1, 32'hEA000010);  // R8 branch
        step(1, 32'hEB123456);  // R8 branch with link
        step(1, 32'hE0010392);  // R4 multiply also fits halfword pattern
        step(1, 32'hE02F0392);  // R10 multiply with r15
        step(1, 32'hE0821394);  // R4 long multiply
        step(1, 32'hE1012092);  // R4 swap over halfword
        step(1, 32'hE10F209F);  // R10 swap with r15
        step(0, 32'hE1D320B4);  // R2 ignored: valid low
        step(1, 32'hE1D320B4);  // R9 halfword load, immediate
        step(1, 32'hE19F20BF);  // R10 halfword register offset r15
        step(1, 32'hE1BF20B4);  // R10 halfword write-back base r15
        step(1, 32'hEF000011);  // R3 software interrupt
        step(1, 32'hED931A00);  // R9 coprocessor transfer
        step(1, 32'hEE012A03);  // R9 coprocessor operation
        step(1, 32'hEE112A70);  // R9 coprocessor register transfer
        step(1, 32'hE0812003);  // R5 unknown
        step(1, 32'h07000010);  // R6 unknown, cond 0
        step(1, 32'hF12FFF10);  // R6 cond F
        // random sweep with gaps and forced overlap bytes
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            w = $urandom();
            if (n % 3 == 0) w[7:4] = 4'b1001;
            if (n % 5 == 0) w[27:24] = 4'($urandom_range(0, 1));
            step(($urandom_range(0, 7) != 0), w);
        end
        step(0, '0);
        step(0, '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule